// File: doc/BRIEF.md
# DDR Read Burst Strobe Sequencer

This block models the memory-device side of a double-data-rate read burst. A READ command carries a starting column, a CAS-latency choice of two or three clocks, and a burst length of two, four or eight words. The block waits out the latency, then drives a one-cycle strobe preamble. It then sends the burst at two words per clock, one in each clock half, with the strobe toggling edge-aligned to the data. The strobe is low during the last word, which is the postamble, and both output enables then drop together.

Read data comes from a small constant column array. Words are fetched in sequential order inside an aligned block of burst-length columns. High impedance on the pins is represented by the two output enables: a pad driver puts the line into high impedance when its enable is low. Only one burst is in flight at a time. A command that arrives while a burst is pending or running is dropped.

Top module: `ddr_rd_burst`

## Requirements
- R1: While rst_n is low, and after reset until a command is accepted, dqs_oe, dq_oe, dqs and dq are all zero. A command presented during reset starts no burst.
- R2: A command accepted at clock edge k places its first data word in the clock cycle after edge k+2 when cl_sel=0, and after edge k+3 when cl_sel=1.
- R3: In the one clock cycle just before the first data cycle (the preamble), dqs_oe=1 with dqs=0 for the whole cycle and dq_oe=0.
- R4: In each data cycle, dq_oe=1 and dqs_oe=1. The even word is on dq while clk is high, with dqs=1. The odd word is on dq while clk is low, with dqs=0.
- R5: bl_sel selects the burst length: 2'b00 is 2 words, 2'b01 is 4 words, and 2'b10 or 2'b11 is 8 words. The burst occupies length/2 consecutive data cycles.
- R6: Word i of a burst (i from 0) is read from column base | ((start + i) mod L). L is the burst length and base is the start column with its low log2(L) bits cleared.
- R7: The strobe is low while the last word is out (the postamble). At the edge that ends the last data cycle, dqs_oe and dq_oe fall together. Whenever an enable is low, its line (dqs or dq) reads zero.
- R8: rd_cmd is sampled only when no burst is pending. From the accepting edge up to and including the edge that ends the last data cycle, commands are ignored. A change to rd_col, cl_sel or bl_sel during that window has no effect on the running burst.
- R9: The array word at column c is the 16-bit value (c * 16'h1111) xor 16'h5A3C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; data moves on both of its edges |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_cmd | input | 1 | READ command strobe, sampled at the rising edge |
| rd_col | input | COL_W (4) | Starting column of the burst |
| cl_sel | input | 1 | CAS latency: 0 = 2 clocks, 1 = 3 clocks |
| bl_sel | input | 2 | Burst length select (see R5) |
| dqs | output | 1 | Data strobe value |
| dqs_oe | output | 1 | Strobe output enable (low = high impedance) |
| dq | output | DW (16) | Read data value |
| dq_oe | output | 1 | Data output enable (low = high impedance) |

## Verification
Directed bursts cover the two latencies and all three lengths. They use start columns at the bottom of an aligned block, in the middle of it, and at the top of the array, so that a wrong wrap point or a wrong base column shows up as a wrong word. Random bursts add back-to-back commands and mix in extra READs, plus changes to the latency, length and column inputs, at a random point inside the burst window. Each half cycle is compared with the expected strobe, enables and data. A wrongly accepted command then shows up either as a corrupted burst or as an extra preamble after the release edge. A reset phase with rd_cmd held high confirms that nothing starts before a command is legally accepted.

// File: rtl/ddr_rd_pkg.sv
// Shared types and helpers for the DDR read burst sequencer.
// Assumes burst lengths of 2, 4 or 8 words selected by a 2-bit code.
package ddr_rd_pkg;

    // Longest supported burst in words
    localparam int unsigned MAX_BL    = 8;
    // Clock cycles needed for the longest burst
    localparam int unsigned MAX_BEATS = MAX_BL / 2;
    localparam int unsigned BEAT_W    = $clog2(MAX_BEATS);

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PRE   = 2'd2,
        ST_BURST = 2'd3
    } rd_state_e;

    // Number of clock cycles (two words each) for a burst-length code
    function automatic int unsigned beats_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/ddr_rd_ctrl.sv
// Command capture and phase sequencing.
// Accepts a READ only in idle, latches column and length, counts the
// latency down, then steps through preamble and burst cycles.
// Assumes a CAS latency of 2 or 3, so one or two wait cycles.
module ddr_rd_ctrl
    import ddr_rd_pkg::*;
#(
    parameter int unsigned COL_W = 4,
    parameter int unsigned LAT_W = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_cmd,
    input  logic [COL_W-1:0]     rd_col,
    input  logic                 cl_sel,
    input  logic [1:0]           bl_sel,
    output rd_state_e            state,
    output logic [BEAT_W-1:0]    beat,
    output logic [COL_W-1:0]     col_q,
    output logic [1:0]           bl_q
);

    logic [LAT_W-1:0]  wait_cnt;
    logic [BEAT_W-1:0] last_beat;

    // Index of the final data cycle for the latched length
    always_comb begin
        last_beat = BEAT_W'(beats_of(bl_q) - 1);
    end

    // Phase register, latency counter, beat counter and command latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            beat     <= '0;
            col_q    <= '0;
            bl_q     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (rd_cmd) begin
                        col_q    <= rd_col;
                        bl_q     <= bl_sel;
                        wait_cnt <= LAT_W'(cl_sel);
                        state    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wait_cnt == '0) begin
                        state <= ST_PRE;
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                ST_PRE: begin
                    beat  <= '0;
                    state <= ST_BURST;
                end
                default: begin
                    if (beat == last_beat) begin
                        state <= ST_IDLE;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/ddr_rd_addr.sv
// Burst column generator.
// Produces the two columns read in one data cycle, in sequential order
// with wrap inside the aligned block of burst-length columns.
// Assumes COL_W is at least log2 of the longest burst.
module ddr_rd_addr
    import ddr_rd_pkg::*;
#(
    parameter int unsigned COL_W = 4
) (
    input  logic [COL_W-1:0]  col_q,
    input  logic [1:0]        bl_q,
    input  logic [BEAT_W-1:0] beat,
    output logic [COL_W-1:0]  addr_even,
    output logic [COL_W-1:0]  addr_odd
);

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] ofs;

    // Wrap mask, block base and word offset of this cycle
    always_comb begin
        mask = COL_W'(2 * beats_of(bl_q) - 1);
        base = col_q & ~mask;
        ofs  = COL_W'({beat, 1'b0});
    end

    // Columns of the rising-half and falling-half words
    always_comb begin
        addr_even = base | ((col_q + ofs) & mask);
        addr_odd  = base | ((col_q + ofs + 1'b1) & mask);
    end

endmodule

// File: rtl/ddr_rd_rom.sv
// Constant column array with two read ports.
// Each entry is a fixed function of its column; no write path exists.
// Assumes DEPTH stays small (one entry per column).
module ddr_rd_rom #(
    parameter int unsigned          COL_W = 4,
    parameter int unsigned          DW    = 16,
    parameter logic [DW-1:0]        MUL   = 16'h1111,
    parameter logic [DW-1:0]        XORV  = 16'h5A3C
) (
    input  logic [COL_W-1:0] addr_a,
    input  logic [COL_W-1:0] addr_b,
    output logic [DW-1:0]    data_a,
    output logic [DW-1:0]    data_b
);

    localparam int unsigned DEPTH = 1 << COL_W;

    logic [DW-1:0] table_q [DEPTH];

    // One constant entry per column
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        assign table_q[gi] = (DW'(gi) * MUL) ^ XORV;
    end

    // Two independent reads
    always_comb begin
        data_a = table_q[addr_a];
        data_b = table_q[addr_b];
    end

endmodule

// File: rtl/ddr_rd_io.sv
// Pin-side shaping of strobe and data.
// Builds the preamble, the edge-aligned strobe and the two-per-cycle
// data from the phase, using the clock level to select the half.
// Assumes outputs are read by a pad driver that tristates on low enable.
module ddr_rd_io
    import ddr_rd_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  rd_state_e     state,
    input  logic [DW-1:0] w_even,
    input  logic [DW-1:0] w_odd,
    output logic          dqs,
    output logic          dqs_oe,
    output logic [DW-1:0] dq,
    output logic          dq_oe
);

    // Enables follow the phase; strobe is driven in preamble and burst
    always_comb begin
        dqs_oe = (state == ST_PRE) || (state == ST_BURST);
        dq_oe  = (state == ST_BURST);
    end

    // Strobe and data track the clock half during the burst, else zero
    always_comb begin
        dqs = dq_oe & clk;
        if (!dq_oe) begin
            dq = '0;
        end else if (clk) begin
            dq = w_even;
        end else begin
            dq = w_odd;
        end
    end

endmodule

// File: rtl/ddr_rd_burst.sv
// DDR read burst strobe sequencer, top level.
// Takes a READ with column, latency and length; emits preamble,
// double-rate data with strobe, postamble and release.
// Assumes a single outstanding burst; commands while busy are dropped.
module ddr_rd_burst
    import ddr_rd_pkg::*;
#(
    parameter int unsigned   COL_W = 4,
    parameter int unsigned   DW    = 16,
    parameter logic [DW-1:0] MUL   = 16'h1111,
    parameter logic [DW-1:0] XORV  = 16'h5A3C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_cmd,
    input  logic [COL_W-1:0] rd_col,
    input  logic             cl_sel,
    input  logic [1:0]       bl_sel,
    output logic             dqs,
    output logic             dqs_oe,
    output logic [DW-1:0]    dq,
    output logic             dq_oe
);

    rd_state_e         state;
    logic [BEAT_W-1:0] beat;
    logic [COL_W-1:0]  col_q;
    logic [1:0]        bl_q;
    logic [COL_W-1:0]  addr_even;
    logic [COL_W-1:0]  addr_odd;
    logic [DW-1:0]     w_even;
    logic [DW-1:0]     w_odd;

    ddr_rd_ctrl #(.COL_W(COL_W), .LAT_W(1)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_cmd (rd_cmd),
        .rd_col (rd_col),
        .cl_sel (cl_sel),
        .bl_sel (bl_sel),
        .state  (state),
        .beat   (beat),
        .col_q  (col_q),
        .bl_q   (bl_q)
    );

    ddr_rd_addr #(.COL_W(COL_W)) u_addr (
        .col_q     (col_q),
        .bl_q      (bl_q),
        .beat      (beat),
        .addr_even (addr_even),
        .addr_odd  (addr_odd)
    );

    ddr_rd_rom #(.COL_W(COL_W), .DW(DW), .MUL(MUL), .XORV(XORV)) u_rom (
        .addr_a (addr_even),
        .addr_b (addr_odd),
        .data_a (w_even),
        .data_b (w_odd)
    );

    ddr_rd_io #(.DW(DW)) u_io (
        .clk    (clk),
        .state  (state),
        .w_even (w_even),
        .w_odd  (w_odd),
        .dqs    (dqs),
        .dqs_oe (dqs_oe),
        .dq     (dq),
        .dq_oe  (dq_oe)
    );

endmodule

// File: rtl/ddr_rd_burst_chk.sv
// Protocol checker for the read burst sequencer, bound to the top.
// Watches the two enables at the rising edge; a counter bounds burst length.
module ddr_rd_burst_chk
    import ddr_rd_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic dqs_oe,
    input logic dq_oe
);

    logic [BEAT_W:0] run_cnt;

    // Count consecutive data cycles seen so far
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (dq_oe) begin
            run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

    a_r4_data_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> dqs_oe);

    a_r3_pre_before_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dqs_oe) |-> !dq_oe);

    a_r3_pre_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (dqs_oe && !dq_oe) |=> dq_oe);

    a_r7_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> !dqs_oe);

    a_r5_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (run_cnt < (BEAT_W+1)'(MAX_BEATS)));

endmodule

bind ddr_rd_burst ddr_rd_burst_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .dqs_oe (dqs_oe),
    .dq_oe  (dq_oe)
);

// File: tb/ddr_rd_burst_tb.sv
module ddr_rd_burst_tb;

    localparam int unsigned COL_W = 4;
    localparam int unsigned DW    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_cmd = 1'b0;
    logic [COL_W-1:0] rd_col = '0;
    logic             cl_sel = 1'b0;
    logic [1:0]       bl_sel = 2'b00;
    logic             dqs;
    logic             dqs_oe;
    logic [DW-1:0]    dq;
    logic             dq_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    ddr_rd_burst u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_cmd (rd_cmd),
        .rd_col (rd_col),
        .cl_sel (cl_sel),
        .bl_sel (bl_sel),
        .dqs    (dqs),
        .dqs_oe (dqs_oe),
        .dq     (dq),
        .dq_oe  (dq_oe)
    );

    // R9 array content
    function automatic logic [DW-1:0] word_at(input logic [COL_W-1:0] c);
        return (DW'(c) * 16'h1111) ^ 16'h5A3C;
    endfunction

    // R5 length in words
    function automatic int len_of(input logic [1:0] s);
        return (s == 2'b00) ? 2 : (s == 2'b01) ? 4 : 8;
    endfunction

    // R6 column of word i
    function automatic logic [COL_W-1:0] col_of(input logic [COL_W-1:0] st,
                                                input int len, input int i);
        logic [COL_W-1:0] m;
        m = COL_W'(len - 1);
        return (st & ~m) | ((st + COL_W'(i)) & m);
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] pins();
        return {13'd0, dqs_oe, dqs, dq_oe, dq};
    endfunction

    // One burst with per-half checking; poke adds ignored commands (R8)
    task automatic do_burst(input logic [COL_W-1:0] col, input bit cl3,
                            input logic [1:0] bls, input bit poke);
        int cl   = cl3 ? 3 : 2;
        int len  = len_of(bls);
        int last = cl + len / 2;
        @(negedge clk);
        rd_cmd = 1'b1; rd_col = col; cl_sel = cl3; bl_sel = bls;
        @(posedge clk);
        for (int j = 0; j <= last + 3; j++) begin
            for (int h = 0; h < 2; h++) begin
                logic [31:0] e;
                string tag;
                #5;
                if (j < cl - 1) begin
                    e = 32'd0; tag = "R2";
                end else if (j == cl - 1) begin
                    e = {13'd0, 1'b1, 1'b0, 1'b0, 16'd0}; tag = "R3 R2";
                end else if (j < last) begin
                    int b = j - cl;
                    logic [DW-1:0] w;
                    w = word_at(col_of(col, len, 2 * b + h));
                    e = {13'd0, 1'b1, (h == 0), 1'b1, w};
                    tag = (j == last - 1 && h == 1) ? "R7 R4 R6 R9" : "R4 R5 R6 R9";
                end else begin
                    e = 32'd0; tag = poke ? "R8 R7" : "R7 R5";
                end
                check(tag, pins(), e);
                if (h == 0) begin
                    @(negedge clk);
                    if (poke && (j == 0 || j == cl)) begin
                        rd_cmd = 1'b1; rd_col = ~col; cl_sel = ~cl3; bl_sel = ~bls;
                    end else begin
                        rd_cmd = 1'b0;
                    end
                end else begin
                    @(posedge clk);
                end
            end
        end
    endtask

    initial begin
        void'($urandom(32'h1D2C));
        // R1: reset with a command pending
        rd_cmd = 1'b1; rd_col = 4'd3; bl_sel = 2'b01;
        repeat (3) @(posedge clk);
        #5 check("R1", pins(), 32'd0);
        @(negedge clk); rd_cmd = 1'b0; rst_n = 1'b1;
        repeat (4) begin
            @(posedge clk); #5 check("R1", pins(), 32'd0);
        end
        // Directed corners
        do_burst(4'd0,  1'b0, 2'b00, 1'b0);
        do_burst(4'd7,  1'b1, 2'b10, 1'b0);
        do_burst(4'd5,  1'b0, 2'b01, 1'b1);
        do_burst(4'd15, 1'b1, 2'b00, 1'b1);
        do_burst(4'd10, 1'b0, 2'b11, 1'b1);
        do_burst(4'd9,  1'b1, 2'b01, 1'b0);
        // Random mix
        for (int n = 0; n < 60; n++) begin
            do_burst(COL_W'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule